// File: doc/BRIEF.md
# External Interrupt Request Latch

This block turns one active-low external interrupt pin into a latched interrupt request for a CPU. The pin first passes through a synchronizer. A falling edge on the synchronized pin sets a request latch. A one-bit mode control picks one of two clearing rules:
- **Edge-only mode:** an acknowledge clears the latch at once.
- **Edge-plus-level mode:** the latch stays set while the pin is low. It clears only after it has seen both an acknowledge and the pin back at 1, in whichever order those two arrive.

An acknowledge comes from either of two sources: a vector-fetch strobe from the CPU, or software writing 1 to the acknowledge bit of the control/status register. A mask bit blocks the request from reaching the CPU. A pending flag reports the latch state whatever the mask is. While the CPU interrupt output is active, the vector address output carries the address of the vector pair.

Software reaches the block through a single 4-bit register:
- **Writes** take effect at the next clock edge.
- **Reads** are combinational.

Top module: `ext_irq_ctrl`

## Requirements
- R1: A falling edge on `irq_pin_n` sets the pending latch. `reg_rdata[3]` rises after the third rising clock edge that follows the pin change: two synchronizer stages, then the latch.
- R2: In edge-only mode (`reg_rdata[0]`=0), an acknowledge clears the latch at the next clock edge. A pin held low does not set it again.
- R3: In edge-plus-level mode (`reg_rdata[0]`=1), the latch stays set while the synchronized pin is low, even if an acknowledge arrives.
- R4: In edge-plus-level mode, the latch clears only once both have happened: an acknowledge, and the synchronized pin back at 1. The two may arrive in either order.
- R5: A register write with bit 2 set is an acknowledge equal to a `vec_fetch` pulse. Bit 2 always reads 0. A falling edge after the acknowledge latches a new request.
- R6: If a falling edge and an acknowledge land in the same cycle, the latch stays set.
- R7: `reg_rdata[3]` shows the latch state whatever the mask bit is. `cpu_irq` is high only when the latch is set and the mask bit (bit 1) is 0.
- R8: `vec_addr` equals 0xFFFA while `cpu_irq` is high, and 0 otherwise.
- R9: Reset clears the latch, the mode bit and the mask bit. The latch stays clear after reset even if the pin is still low.
- R10: A register write loads bit 1 (mask) and bit 0 (mode). Bit 3 is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 1 | External interrupt pin, active low, asynchronous |
| reg_wr | input | 1 | Write strobe for the control/status register |
| reg_wdata | input | 4 | Write data: bit 2 acknowledge, bit 1 mask, bit 0 mode |
| reg_rdata | output | 4 | Read data: bit 3 pending, bit 2 reads 0, bit 1 mask, bit 0 mode |
| vec_fetch | input | 1 | CPU vector-fetch strobe; acts as an acknowledge |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| vec_addr | output | 16 | Vector address while the request is taken |

## Verification
A newly detected falling edge can fall in the same cycle as an acknowledge. That acknowledge may come from either the vector fetch or the register write.

The bench provokes the collision as follows:
1. It holds an older request latched.
2. It drops the pin.
3. It counts the two synchronizer edges so that the acknowledge pulse sits exactly in the cycle where the edge is decoded.

The result is judged correct if the latch is still set afterwards. A second, lone acknowledge must then clear it, which shows that the first acknowledge was in fact taken.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    // Register field positions (behaviour depends on them)
    localparam int MODE_BIT  = 0;
    localparam int MASK_BIT  = 1;
    localparam int ACK_BIT   = 2;
    localparam int PEND_BIT  = 3;
    localparam int REG_W     = 4;

    typedef struct packed {
        logic pend;      // request latch
        logic ack_seen;  // acknowledge already taken, waiting for pin high
    } latch_state_t;

    typedef struct packed {
        logic mask;
        logic mode;
    } ctrl_state_t;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_i,
    output logic pin_high_o,
    output logic fall_o
);
    // Flops reset to 0 so that reset never invents a falling edge
    logic [STAGES-1:0] sync_d, sync_q;
    logic              prev_d, prev_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], pin_n_i};
        prev_d = sync_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign pin_high_o = sync_q[STAGES-1];
    assign fall_o     = prev_q & ~sync_q[STAGES-1];

    initial begin
        stages_min_chk: assert (STAGES >= 2);
    end
endmodule

// File: rtl/irqc_latch.sv
module irqc_latch
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_i,
    input  logic fall_i,
    input  logic pin_high_i,
    input  logic ack_i,
    output logic pend_o
);
    latch_state_t st_d, st_q;
    logic         ack_done;

    always_comb begin
        st_d     = st_q;
        ack_done = ack_i | st_q.ack_seen;
        if (!mode_i) begin
            // edge-only: acknowledge clears at once, new edge wins
            st_d.pend     = fall_i | (st_q.pend & ~ack_i);
            st_d.ack_seen = 1'b0;
        end else begin
            // edge plus level: low pin holds the request
            st_d.pend     = fall_i | ~pin_high_i |
                            (st_q.pend & ~(ack_done & pin_high_i));
            st_d.ack_seen = st_d.pend & ~fall_i & ack_done;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    // R1
    edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_i |=> pend_o);
    // R2
    edge_mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && ack_i && !fall_i) |=> !pend_o);
    // R3
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && !pin_high_i) |=> pend_o);
    // R4
    level_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && pend_o && pin_high_i && (ack_i || st_q.ack_seen) && !fall_i)
        |=> !pend_o);
    // R6
    collide_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_i && ack_i) |=> pend_o);
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             pend_i,
    output logic [REG_W-1:0] rdata_o,
    output logic             sw_ack_o,
    output logic             mode_o,
    output logic             mask_o
);
    ctrl_state_t ctl_d, ctl_q;
    logic        unused_pend_wr;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_i) begin
            ctl_d.mask = wdata_i[MASK_BIT];
            ctl_d.mode = wdata_i[MODE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign unused_pend_wr = wdata_i[PEND_BIT];
    assign sw_ack_o       = wr_i & wdata_i[ACK_BIT];
    assign mode_o         = ctl_q.mode;
    assign mask_o         = ctl_q.mask;

    always_comb begin
        rdata_o           = '0;
        rdata_o[PEND_BIT] = pend_i;
        rdata_o[MASK_BIT] = ctl_q.mask;
        rdata_o[MODE_BIT] = ctl_q.mode;
    end

    // R10
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (mask_o == $past(wdata_i[MASK_BIT])) && (mode_o == $past(wdata_i[MODE_BIT])));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter int          ADDR_W      = 16,
    parameter logic [15:0] VEC_ADDR    = 16'hFFFA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_pin_n,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              vec_fetch,
    output logic              cpu_irq,
    output logic [ADDR_W-1:0] vec_addr
);
    localparam logic [ADDR_W-1:0] VEC = ADDR_W'(VEC_ADDR);

    logic pin_high, fall, pend, sw_ack, mode, mask, ack;

    irqc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_n_i(irq_pin_n),
        .pin_high_o(pin_high), .fall_o(fall)
    );

    irqc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .wdata_i(reg_wdata),
        .pend_i(pend), .rdata_o(reg_rdata), .sw_ack_o(sw_ack),
        .mode_o(mode), .mask_o(mask)
    );

    assign ack = vec_fetch | sw_ack;

    irqc_latch u_latch (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .fall_i(fall),
        .pin_high_i(pin_high), .ack_i(ack), .pend_o(pend)
    );

    assign cpu_irq  = pend & ~mask;
    assign vec_addr = cpu_irq ? VEC : '0;

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (reg_rdata == '0));
    // R7
    mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[MASK_BIT] |-> !cpu_irq);
    // R8
    vec_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> (vec_addr == VEC));
endmodule

// File: tb/sim_ext_irq_ctrl.sv
module sim_ext_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_n = 1'b1;
    logic        wr = 1'b0;
    logic [3:0]  wdata = 4'h0;
    logic [3:0]  rdata;
    logic        vf = 1'b0;
    logic        irq;
    logic [15:0] vaddr;
    int          n_chk = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    ext_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_pin_n(pin_n), .reg_wr(wr),
        .reg_wdata(wdata), .reg_rdata(rdata), .vec_fetch(vf),
        .cpu_irq(irq), .vec_addr(vaddr)
    );

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [3:0] v);
        wr = 1'b1; wdata = v;
        cyc(1);
        wr = 1'b0; wdata = 4'h0;
    endtask

    task automatic vfetch();
        vf = 1'b1;
        cyc(1);
        vf = 1'b0;
    endtask

    task automatic pin_up();
        pin_n = 1'b1;
        cyc(4);
    endtask

    task automatic t_reset();
        chk("R9 rdata after reset", 16'(rdata), 16'h0);
        chk("R9 cpu_irq after reset", 16'(irq), 16'h0);
        chk("R8 vec_addr idle", vaddr, 16'h0);
    endtask

    task automatic t_regs();
        wreg(4'b1011);
        chk("R10 mask/mode load, pend read-only", 16'(rdata), 16'h3);
        wreg(4'b0110);
        chk("R5 ack bit reads 0", 16'(rdata), 16'h2);
        wreg(4'b0000);
        chk("R10 clear", 16'(rdata), 16'h0);
    endtask

    task automatic t_edge();
        pin_n = 1'b0;
        cyc(2);
        chk("R1 not yet latched", 16'(rdata[3]), 16'h0);
        cyc(1);
        chk("R1 latched after 3 edges", 16'(rdata[3]), 16'h1);
        chk("R7 cpu_irq unmasked", 16'(irq), 16'h1);
        chk("R8 vector address", vaddr, 16'hFFFA);
        vfetch();
        chk("R2 edge mode ack clears", 16'(rdata[3]), 16'h0);
        cyc(5);
        chk("R2 held low no re-set", 16'(rdata[3]), 16'h0);
        chk("R8 vec_addr zero when idle", vaddr, 16'h0);
        pin_up();
    endtask

    task automatic t_sw_ack();
        pin_n = 1'b0;
        cyc(3);
        chk("R5 latched before sw ack", 16'(rdata[3]), 16'h1);
        wreg(4'b0100);
        chk("R5 sw ack clears", 16'(rdata[3]), 16'h0);
        pin_up();
        pin_n = 1'b0;
        cyc(3);
        chk("R5 new edge after ack latches", 16'(rdata[3]), 16'h1);
        vfetch();
        pin_up();
    endtask

    task automatic t_mask();
        wreg(4'b0010);
        pin_n = 1'b0;
        cyc(3);
        chk("R7 pend visible under mask", 16'(rdata), 16'hA);
        chk("R7 cpu_irq blocked", 16'(irq), 16'h0);
        chk("R8 vec_addr zero when masked", vaddr, 16'h0);
        wreg(4'b0000);
        chk("R7 cpu_irq after unmask", 16'(irq), 16'h1);
        vfetch();
        pin_up();
    endtask

    task automatic t_level_ack_first();
        wreg(4'b0001);
        pin_n = 1'b0;
        cyc(3);
        chk("R3 level latched", 16'(rdata[3]), 16'h1);
        vfetch();
        cyc(4);
        chk("R3 held while pin low after ack", 16'(rdata[3]), 16'h1);
        pin_n = 1'b1;
        cyc(2);
        chk("R4 not cleared before sync", 16'(rdata[3]), 16'h0 | 16'h1);
        cyc(1);
        chk("R4 cleared ack then pin high", 16'(rdata[3]), 16'h0);
        cyc(2);
    endtask

    task automatic t_level_pin_first();
        pin_n = 1'b0;
        cyc(3);
        pin_up();
        cyc(2);
        chk("R4 pin high alone keeps latch", 16'(rdata[3]), 16'h1);
        wreg(4'b0101);
        chk("R4 cleared pin high then ack", 16'(rdata[3]), 16'h0);
        chk("R4 mode kept", 16'(rdata), 16'h1);
        wreg(4'b0000);
    endtask

    task automatic t_same_cycle();
        pin_n = 1'b0;
        cyc(3);
        pin_up();
        chk("R6 older request held", 16'(rdata[3]), 16'h1);
        pin_n = 1'b0;
        cyc(2);
        vfetch();
        chk("R6 edge and ack same cycle keeps latch", 16'(rdata[3]), 16'h1);
        vfetch();
        chk("R6 lone ack then clears", 16'(rdata[3]), 16'h0);
        pin_up();
    endtask

    task automatic t_reset_low();
        wreg(4'b0011);
        pin_n = 1'b0;
        cyc(3);
        chk("R9 latched before reset", 16'(rdata), 16'hB);
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        cyc(5);
        chk("R9 reset clears with pin low", 16'(rdata), 16'h0);
        chk("R9 no cpu_irq after reset", 16'(irq), 16'h0);
        pin_up();
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(4);
        t_reset();
        t_regs();
        t_edge();
        t_sw_ack();
        t_mask();
        t_level_ack_first();
        t_level_pin_first();
        t_same_cycle();
        t_reset_low();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule